// File: doc/BRIEF.md
# Selectable Serial Line Encoder

This block turns a stream of single data bits into one line level, using NRZ, NRZI or Manchester coding. A two-bit mode input picks the coding. An external rate generator supplies a one-cycle pulse at the start of every bit cell and a second one-cycle strobe at the middle of the cell. Data bits arrive over a valid/ready handshake. The encoder offers to take a bit only in the cycle of a cell-start pulse.

When the encoder leaves idle with its preamble request high, it first sends a fixed number of synchronisation cells. The pattern depends on the mode: a run of zeros for NRZI, and alternating ones and zeros, starting with a one, for NRZ and Manchester. Payload bits follow the preamble. When a cell starts and no bit is offered, the encoder goes idle and parks the line at a steady high mark level.

The coding mode is latched when the encoder leaves idle. It is held until the encoder is idle again, so a stream is never coded in two ways.

Top module: `line_encoder`

## Requirements
- R1: After reset, and from any cell start at which nothing is sent, the line is high and the encoder is idle.
- R2: Mode codes 0 and 3 select NRZ: from the clock edge that samples a cell start, the line equals the cell's bit for the whole cell.
- R3: Mode code 1 selects NRZI: at a cell start the line inverts for a 0 and keeps its level for a 1. The reference level is high at the first cell after idle.
- R4: Mode code 2 selects Manchester: the line equals the cell's bit in the first half of the cell, and the inverse of the bit after the mid-cell strobe. A 1 therefore falls and a 0 rises at mid-cell.
- R5: A preamble request that is high at a cell start that leaves idle starts PRE_CELLS preamble cells. Ready stays low for all of these cells, and the first payload bit is taken at the next cell start.
- R6: Preamble cells carry 0 in NRZI mode. In NRZ and Manchester modes they carry 1, 0, 1, 0 and so on, starting with 1.
- R7: Changes on the mode input while the encoder is active have no effect on the coding until the encoder has returned to idle.
- R8: Ready is high only in a cell-start cycle that is not a preamble cell. A bit is consumed only when valid and ready are both high. A cell start with no valid bit sends nothing and goes idle.
- R9: The mid-cell strobe has no effect on the line in NRZ and NRZI modes or while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Coding select: 0 NRZ, 1 NRZI, 2 Manchester, 3 NRZ |
| preamble_req_i | input | 1 | Request a synchronisation preamble when leaving idle |
| cell_tick_i | input | 1 | One-cycle pulse at the start of each bit cell |
| mid_tick_i | input | 1 | One-cycle pulse at the middle of each bit cell |
| bit_i | input | 1 | Data bit offered |
| bit_valid_i | input | 1 | Data bit is valid |
| bit_ready_o | output | 1 | Encoder takes the bit in this cycle |
| line_o | output | 1 | Encoded line level |

## Verification
Two events can land in the same cycle and compete. The first is the decision to go idle or to start a preamble at a cell start, while a data bit is offered in that same cycle. The second is a mode change on the input while a stream is running. The bench provokes the first case by raising the preamble request and valid data together on an idle cell start, and by leaving a one-cell gap in the data so the encoder idles and then restarts with NRZI. It provokes the second by switching the mode input from NRZ to Manchester in the middle of a stream. A behavioural model predicts the line and ready in every cycle, and each difference is reported against the requirement that governs that phase.

// File: rtl/lenc_pkg.sv
package lenc_pkg;

    typedef enum logic [1:0] {
        LC_NRZ   = 2'd0,
        LC_NRZI  = 2'd1,
        LC_MANCH = 2'd2
    } lcode_e;

    // Command from the cell sequencer to the line shaper
    typedef struct packed {
        logic   go;     // a cell starts and carries bit_v
        logic   idle;   // a cell starts and nothing is sent
        logic   bit_v;  // bit carried by the starting cell
        lcode_e code;   // coding in force for the cell
    } cell_cmd_t;

    function automatic lcode_e decode_mode(logic [1:0] m);
        case (m)
            2'd1:    return LC_NRZI;
            2'd2:    return LC_MANCH;
            default: return LC_NRZ;
        endcase
    endfunction

    function automatic logic preamble_bit(lcode_e c, logic odd);
        return (c == LC_NRZI) ? 1'b0 : ~odd;
    endfunction

endpackage

// File: rtl/lenc_seq.sv
module lenc_seq
    import lenc_pkg::*;
#(
    parameter int PRE_CELLS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_i,
    input  logic       preamble_req_i,
    input  logic       cell_tick_i,
    input  logic       bit_i,
    input  logic       bit_valid_i,
    output logic       bit_ready_o,
    output cell_cmd_t  cmd_o
);
    localparam int CW = $clog2(PRE_CELLS + 1);

    logic          active_q;
    lcode_e        mode_q;
    logic [CW-1:0] pre_left_q;
    logic          pre_odd_q;

    lcode_e        mode_eff;
    logic          start_pre;
    logic          in_pre;
    logic          odd_cur;
    logic [CW-1:0] pre_base;

    always_comb begin
        mode_eff    = active_q ? mode_q : decode_mode(mode_i);
        start_pre   = cell_tick_i & ~active_q & preamble_req_i;
        in_pre      = (pre_left_q != '0) | start_pre;
        odd_cur     = start_pre ? 1'b0 : pre_odd_q;
        pre_base    = start_pre ? CW'(PRE_CELLS) : pre_left_q;
        bit_ready_o = cell_tick_i & ~in_pre;
        cmd_o.code  = mode_eff;
        cmd_o.go    = cell_tick_i & (in_pre | bit_valid_i);
        cmd_o.idle  = cell_tick_i & ~in_pre & ~bit_valid_i;
        cmd_o.bit_v = in_pre ? preamble_bit(mode_eff, odd_cur) : bit_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= 1'b0;
            mode_q     <= LC_NRZ;
            pre_left_q <= '0;
            pre_odd_q  <= 1'b0;
        end else begin
            mode_q <= mode_eff;
            if (cell_tick_i) begin
                active_q <= cmd_o.go;
                if (in_pre) begin
                    pre_left_q <= pre_base - CW'(1);
                    pre_odd_q  <= ~odd_cur;
                end
            end
        end
    end

    // R8: ready only in a cell-start cycle
    a_r8_ready_on_tick: assert property (@(posedge clk) disable iff (rst)
        bit_ready_o |-> cell_tick_i);

    // R5: no data accepted while preamble cells remain
    a_r5_no_ready_in_preamble: assert property (@(posedge clk) disable iff (rst)
        (pre_left_q != '0) |-> !bit_ready_o);

endmodule

// File: rtl/lenc_shaper.sv
module lenc_shaper
    import lenc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cell_cmd_t cmd_i,
    input  logic      mid_tick_i,
    output logic      line_o
);
    logic line_q;
    logic cur_q;
    logic manch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= 1'b1;
            cur_q   <= 1'b0;
            manch_q <= 1'b0;
        end else if (cmd_i.go) begin
            cur_q   <= cmd_i.bit_v;
            manch_q <= (cmd_i.code == LC_MANCH);
            if (cmd_i.code == LC_NRZI)
                line_q <= cmd_i.bit_v ? line_q : ~line_q;
            else
                line_q <= cmd_i.bit_v;
        end else if (cmd_i.idle) begin
            line_q  <= 1'b1;
            manch_q <= 1'b0;
        end else if (mid_tick_i && manch_q) begin
            line_q <= ~cur_q;
        end
    end

    assign line_o = line_q;

    // R1: an idle cell parks the line high
    a_r1_idle_mark: assert property (@(posedge clk) disable iff (rst)
        cmd_i.idle |=> line_o);

    // R2: NRZ cell level equals its bit
    a_r2_nrz_level: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.go && cmd_i.code == LC_NRZ) |=> (line_o == $past(cmd_i.bit_v)));

    // R3: NRZI one keeps the level
    a_r3_nrzi_one_holds: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.go && cmd_i.code == LC_NRZI && cmd_i.bit_v) |=> $stable(line_o));

    // R4: Manchester first half equals the bit
    a_r4_manch_first_half: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.go && cmd_i.code == LC_MANCH) |=> (line_o == $past(cmd_i.bit_v)));

endmodule

// File: rtl/line_encoder.sv
module line_encoder
    import lenc_pkg::*;
#(
    parameter int PRE_CELLS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_i,
    input  logic       preamble_req_i,
    input  logic       cell_tick_i,
    input  logic       mid_tick_i,
    input  logic       bit_i,
    input  logic       bit_valid_i,
    output logic       bit_ready_o,
    output logic       line_o
);
    cell_cmd_t cmd;

    lenc_seq #(.PRE_CELLS(PRE_CELLS)) u_seq (
        .clk            (clk),
        .rst            (rst),
        .mode_i         (mode_i),
        .preamble_req_i (preamble_req_i),
        .cell_tick_i    (cell_tick_i),
        .bit_i          (bit_i),
        .bit_valid_i    (bit_valid_i),
        .bit_ready_o    (bit_ready_o),
        .cmd_o          (cmd)
    );

    lenc_shaper u_shape (
        .clk        (clk),
        .rst        (rst),
        .cmd_i      (cmd),
        .mid_tick_i (mid_tick_i),
        .line_o     (line_o)
    );

endmodule

// File: tb/sim_line_encoder.sv
`timescale 1ns/1ps
module sim_line_encoder;
    localparam int PRE = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic       preq = 1'b0;
    logic       tick = 1'b0;
    logic       mid = 1'b0;
    logic       dbit = 1'b0;
    logic       valid = 1'b0;
    logic       ready;
    logic       line;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit q[$];

    // behavioural model state
    bit m_idle = 1'b1;
    bit m_line = 1'b1;
    bit m_cur = 1'b0;
    bit m_pre_cell = 1'b0;
    bit m_after_mid = 1'b0;
    int m_mode = 0;
    int m_pre_left = 0;
    int m_pre_idx = 0;

    line_encoder #(.PRE_CELLS(PRE)) u0 (
        .clk(clk), .rst(rst), .mode_i(mode), .preamble_req_i(preq),
        .cell_tick_i(tick), .mid_tick_i(mid), .bit_i(dbit),
        .bit_valid_i(valid), .bit_ready_o(ready), .line_o(line)
    );

    always #2 clk = ~clk;

    function automatic int dec(logic [1:0] m);
        return (m == 2'd3) ? 0 : int'(m);
    endfunction

    function automatic bit m_ready();
        return tick && (m_pre_left == 0) && !(m_idle && preq);
    endfunction

    always @(posedge clk) begin : model
        bit b;
        bit send;
        if (rst) begin
            m_idle = 1; m_line = 1; m_pre_left = 0; m_pre_idx = 0;
            m_pre_cell = 0; m_after_mid = 0;
        end else begin
            if (m_idle) m_mode = dec(mode);
            if (tick) begin
                send = 0;
                m_after_mid = 0;
                if (m_idle && preq) begin
                    m_pre_left = PRE;
                    m_pre_idx = 0;
                end
                if (m_pre_left > 0) begin
                    b = (m_mode == 1) ? 1'b0 : (m_pre_idx % 2 == 0);
                    m_pre_idx++;
                    m_pre_left--;
                    send = 1;
                    m_pre_cell = 1;
                end else if (valid) begin
                    b = q[0];
                    void'(q.pop_front());
                    send = 1;
                    m_pre_cell = 0;
                end
                if (send) begin
                    m_idle = 0;
                    m_cur = b;
                    if (m_mode == 1) m_line = b ? m_line : !m_line;
                    else m_line = b;
                end else begin
                    m_idle = 1;
                    m_line = 1;
                    m_pre_cell = 0;
                end
            end else if (mid) begin
                if (!m_idle && m_mode == 2) m_line = !m_cur;
                else m_after_mid = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic string line_tag();
        if (!m_idle && dec(mode) != m_mode) return "R7";
        if (m_idle) return "R1";
        if (m_pre_cell) return "R6";
        if (m_after_mid) return "R9";
        if (m_mode == 1) return "R3";
        if (m_mode == 2) return "R4";
        return "R2";
    endfunction

    // per-cycle comparison against the model
    task automatic compare();
        string rt;
        rt = ((m_pre_left > 0) || (m_idle && preq && tick)) ? "R5" : "R8";
        chk(ready === m_ready(), rt, ready, m_ready());
        chk(line === m_line, line_tag(), line, m_line);
    endtask

    task automatic load(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) q.push_back(v[i]);
    endtask

    // cell = 8 cycles: start pulse at phase 0, mid strobe at phase 4
    task automatic run(input int cells, input logic [1:0] md, input bit pr);
        logic l3;
        mode = md;
        for (int c = 0; c < cells; c++) begin
            for (int p = 0; p < 8; p++) begin
                @(negedge clk);
                tick  = (p == 0);
                mid   = (p == 4);
                preq  = pr && (c == 0) && (p == 0);
                valid = (q.size() > 0);
                dbit  = (q.size() > 0) ? q[0] : 1'b0;
                #1;
                compare();
                if (p == 3) l3 = line;
                // R9: mid strobe leaves NRZ/NRZI line untouched
                if (p == 5 && dec(md) != 2)
                    chk(line === l3, "R9", line, l3);
            end
        end
        @(negedge clk);
        tick = 0; mid = 0; preq = 0; valid = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(line === 1'b1, "R1", line, 1);
        chk(ready === 1'b0, "R8", ready, 0);
        @(negedge clk);
        rst = 0;

        run(2, 2'd0, 0);                       // R1 idle cells
        load(16'b0110010, 7); run(9, 2'd0, 0); // R2 NRZ
        load(16'b0110010, 7); run(PRE + 9, 2'd1, 1); // R3 R5 R6 NRZI
        load(16'b11010011, 8); run(PRE + 10, 2'd2, 1); // R4 R6 Manchester
        load(16'b1011001110, 10);
        run(3, 2'd0, 0); run(10, 2'd2, 0);     // R7 mode change mid-stream
        load(16'b1001, 4); run(6, 2'd2, 0);    // Manchester after idle
        load(16'b011, 3); run(4, 2'd1, 0);     // R3 gap resets reference
        load(16'b001, 3); run(4, 2'd1, 0);
        load(16'b1100, 4); run(5, 2'd3, 0);    // R2 code 3
        load(16'b101, 3); run(PRE + 4, 2'd0, 1); // R6 NRZ preamble

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule